// File: doc/BRIEF.md
# Quarter-Square Table Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product without a partial-product array and without one table indexed by both operands. It uses the identity x*y = ((x+y)^2 - (x-y)^2)/4. The operand sum, N+1 bits wide, addresses a table of quarter squares. The magnitude of the operand difference, N bits wide, addresses a second table that holds negated quarter squares. One adder combines the two table words into the product.

Both tables are built during elaboration by a constant function in the package, so no memory image file is needed. The quarter of a square is taken by dropping its two low bits. Those bits are always 00 or 01, and the sum and the difference have the same parity, so nothing is lost in the result. An optional output register holds the product together with a valid flag. With that register present, each operand pair presented with `in_valid` gives its product one clock later.

Top module: `quarter_square_mult`

## Requirements
- R1: For every pair of unsigned N-bit operands, the product output equals the exact 2N-bit value of a_in times b_in.
- R2: With the output register enabled (default), out_valid is high in the cycle after each cycle in which in_valid is high, and low after each cycle in which in_valid is low. The product shown with it belongs to the operands of that earlier cycle.
- R3: A synchronous active-high reset drives out_valid and product to zero at the next clock edge, even if in_valid is high at that edge.
- R4: While in_valid is low, the registered product keeps its last value whatever the operand inputs do.
- R5: Operand pairs whose sum needs N+1 bits (for example 255 and 255 when N is 8) give the correct product.
- R6: The result does not depend on operand order, and equal operands (zero difference) give the exact square.
- R7: A zero operand on either input gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is presented this cycle |
| a_in | input | N | First unsigned operand |
| b_in | input | N | Second unsigned operand |
| out_valid | output | 1 | Product output carries a new result |
| product | output | 2N | Unsigned product of the operands |

## Verification
The bound checker tests four things on every clock edge: the one-cycle valid timing, the absence of a result after an idle cycle, the match between each registered product and the operands of the previous cycle, and the product holding steady while no request arrives. The reset clearing is checked each cycle reset was high on the prior edge. Only the bench's scenarios can show that every operand pair in the full space is right. The same holds for the 9-bit sum corner, swapped operand order, zero operands, and reset arriving during a live request.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

    // Widest operand the constant table generator supports.
    localparam int unsigned QSM_MAX_N = 31;

    // Square of v with its two low bits removed.
    function automatic longint unsigned quarter_sq(input longint unsigned v);
        return (v * v) >> 2;
    endfunction

    // Two's complement of the quarter square, kept to w bits.
    function automatic longint unsigned neg_quarter_sq(input longint unsigned v,
                                                       input int unsigned w);
        longint unsigned mask;
        mask = (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
        return (~quarter_sq(v) + 64'd1) & mask;
    endfunction

    // Table indices produced by the operand stage.
    typedef struct packed {
        logic [QSM_MAX_N:0]   sum_idx;
        logic [QSM_MAX_N-1:0] diff_idx;
    } qsm_idx_t;

endpackage

// File: rtl/qsm_operand_prep.sv
module qsm_operand_prep
    import qsm_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N:0]   sum_idx,
    output logic [N-1:0] diff_idx
);
    logic a_ge_b;

    // Full-width sum needs one extra bit.
    assign sum_idx = {1'b0, op_a} + {1'b0, op_b};

    // Larger minus smaller keeps the index non-negative.
    assign a_ge_b   = (op_a >= op_b);
    assign diff_idx = a_ge_b ? (op_a - op_b) : (op_b - op_a);

endmodule

// File: rtl/qsm_square_rom.sv
module qsm_square_rom
    import qsm_pkg::*;
#(
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned DATA_W = 16,
    parameter bit          NEGATE = 1'b0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        if (NEGATE) begin : g_neg
            localparam longint unsigned VAL = neg_quarter_sq(longint'(i), DATA_W);
            assign table_q[i] = DATA_W'(VAL);
        end else begin : g_pos
            localparam longint unsigned VAL = quarter_sq(longint'(i));
            assign table_q[i] = DATA_W'(VAL);
        end
    end

    assign word = table_q[idx];

endmodule

// File: rtl/qsm_out_stage.sv
module qsm_out_stage #(
    parameter int unsigned W   = 16,
    parameter bit          REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         v_in,
    input  logic [W-1:0] d_in,
    output logic         v_out,
    output logic [W-1:0] d_out
);
    if (REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                v_out <= 1'b0;
                d_out <= '0;
            end else begin
                v_out <= v_in;
                if (v_in) d_out <= d_in;
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign v_out = v_in;
        assign d_out = d_in;
    end

endmodule

// File: rtl/quarter_square_mult.sv
module quarter_square_mult
    import qsm_pkg::*;
#(
    parameter int unsigned N       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic           out_valid,
    output logic [2*N-1:0] product
);
    localparam int unsigned PW = 2 * N;

    logic [N:0]    sum_idx;
    logic [N-1:0]  diff_idx;
    logic [PW-1:0] sq_sum;
    logic [PW-1:0] sq_diff_neg;
    logic [PW-1:0] prod_comb;

    qsm_operand_prep #(.N(N)) u_prep (
        .op_a     (a_in),
        .op_b     (b_in),
        .sum_idx  (sum_idx),
        .diff_idx (diff_idx)
    );

    qsm_square_rom #(.IDX_W(N + 1), .DATA_W(PW), .NEGATE(1'b0)) u_sum_rom (
        .idx  (sum_idx),
        .word (sq_sum)
    );

    qsm_square_rom #(.IDX_W(N), .DATA_W(PW), .NEGATE(1'b1)) u_diff_rom (
        .idx  (diff_idx),
        .word (sq_diff_neg)
    );

    // Second table is already negated: a plain add finishes the product.
    assign prod_comb = sq_sum + sq_diff_neg;

    qsm_out_stage #(.W(PW), .REG(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .v_in  (in_valid),
        .d_in  (prod_comb),
        .v_out (out_valid),
        .d_out (product)
    );

endmodule

// File: rtl/qsm_checker.sv
module qsm_checker #(
    parameter int unsigned N       = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N-1:0]   a_in,
    input logic [N-1:0]   b_in,
    input logic           out_valid,
    input logic [2*N-1:0] product
);
    if (REG_OUT) begin : g_reg_chk
        logic rst_q = 1'b0;
        always_ff @(posedge clk) rst_q <= rst;

        // R3: a reset edge leaves the outputs cleared.
        always_ff @(posedge clk) begin
            if (rst_q) begin
                p_reset_clear_r3: assert (!out_valid && product == '0)
                    else $error("reset did not clear outputs");
            end
        end

        p_latency_r2: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);

        p_idle_r2: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);

        p_product_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (product == (2*N)'($past(a_in)) * (2*N)'($past(b_in))));

        p_hold_r4: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(product));
    end else begin : g_comb_chk
        p_product_comb_r1: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> (product == (2*N)'(a_in) * (2*N)'(b_in)));

        p_valid_comb_r2: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end

endmodule

bind quarter_square_mult qsm_checker #(.N(N), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/quarter_square_mult_tb.sv
module quarter_square_mult_tb;
    localparam int unsigned N  = 8;
    localparam int unsigned PW = 2 * N;
    localparam int unsigned WATCHDOG_CYCLES = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [N-1:0]  a_in = '0;
    logic [N-1:0]  b_in = '0;
    logic          out_valid;
    logic [PW-1:0] product;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [PW-1:0] exp_q [$];

    always #2 clk = ~clk;

    quarter_square_mult #(.N(N), .REG_OUT(1'b1)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: present one pair and queue its expected product.
    task automatic drive(input int a, input int b);
        @(negedge clk);
        a_in     = N'(a);
        b_in     = N'(b);
        in_valid = 1'b1;
        exp_q.push_back(PW'(a * b));
    endtask

    // Directed case: one request, then look at the port a cycle later.
    task automatic one_shot(input int a, input int b, input string req);
        drive(a, b);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
        check(product == PW'(a * b), req, longint'(product), longint'(a * b));
    endtask

    // Monitor: pop and compare each result as it appears.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", 1, 0);
            end else begin
                logic [PW-1:0] e;
                e = exp_q.pop_front();
                check(product == e, "R1", longint'(product), longint'(e));
            end
        end
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state.
        check(out_valid == 1'b0, "R3", longint'(out_valid), 0);
        check(product == '0, "R3", longint'(product), 0);
        @(negedge clk);
        rst = 1'b0;

        // R5: sum needs the extra bit.
        one_shot(255, 255, "R5");
        one_shot(200, 100, "R5");
        // R6: operand order and zero difference.
        one_shot(3, 250, "R6");
        one_shot(250, 3, "R6");
        one_shot(17, 17, "R6");
        // R7: zero operands.
        one_shot(0, 255, "R7");
        one_shot(255, 0, "R7");

        // R4: idle cycles with changing operands keep the product.
        one_shot(77, 3, "R1");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            a_in = N'(k * 37 + 5);
            b_in = N'(k * 11 + 9);
            check(out_valid == 1'b0, "R2", longint'(out_valid), 0);
            check(product == PW'(231), "R4", longint'(product), 231);
        end

        // R3: reset during a live request wins.
        @(negedge clk);
        a_in = 8'd9; b_in = 8'd9; in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R3", longint'(out_valid), 0);
        check(product == '0, "R3", longint'(product), 0);
        in_valid = 1'b0;
        rst = 1'b0;

        // R1: every operand pair, back to back.
        for (int a = 0; a < (1 << N); a++) begin
            for (int b = 0; b < (1 << N); b++) begin
                drive(a, b);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2", longint'(exp_q.size()), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule